// File: doc/BRIEF.md
# LED and Key Register Peripheral

This block is a small memory-mapped peripheral that sits on an AXI4-Lite slave port and gives a processor access to four board push keys and four board LEDs. It holds four 32-bit word registers. One returns a fixed identification word chosen at instantiation. One returns the live state of the keys. One stores the LED pattern and drives the LED pins directly. The last is a plain scratch word that software can use to test the bus path.

Software reads the identification word to check which build is loaded, polls the key register to see which keys are held, and writes the LED register to light any subset of the four LEDs. The key pins are asynchronous to the bus clock. They pass through a two-stage synchronizer before they can reach read data. Write address and write data are accepted independently. Each write completes with a single response that stays valid until the master takes it.

Top module: `pinctl_axil`

## Requirements
- R1: While rst_n is low and directly after it rises, `led_o` is 0, `s_bvalid` and `s_rvalid` are 0, and the LED and scratch registers read back as 0.
- R2: A read with address bits [3:2] = 0 returns the `VERSION` parameter word, and an override of that parameter in the parent changes the returned word.
- R3: A read with address bits [3:2] = 1 returns `key_i` in bits [3:0] and zero in bits [31:4]. The value comes through two synchronizer flops, so a read accepted on the second clock edge after `key_i` changes still returns the old value.
- R4: A write with address bits [3:2] = 2 and `s_wstrb[0]` set loads `s_wdata[3:0]` into the LED register. `led_o` equals that register from the clock edge that commits the write, and a read of the same address returns it in bits [3:0] with zero in bits [31:4].
- R5: Address bits [3:2] = 3 select a 32-bit scratch register. It reads back exactly what was written and has no effect on `led_o`.
- R6: Byte lane n of a write (bits [8n+7:8n]) updates its register only when `s_wstrb[n]` is 1. All other lanes keep their old contents.
- R7: Writes to address bits [3:2] = 0 or 1 change no register. They still receive an OKAY response.
- R8: The write address and write data may be accepted in either order or in the same cycle. A register changes only after both have been accepted.
- R9: Each write produces exactly one response with `s_bresp` = 2'b00 (OKAY). `s_bvalid` stays high until a cycle with `s_bready` high.
- R10: Each accepted read produces one response with `s_rresp` = 2'b00. `s_rvalid` and `s_rdata` stay unchanged until a cycle with `s_rready` high.
- R11: Address bits [1:0] are ignored: addresses 4k through 4k+3 reach the same register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_awaddr | input | ADDR_W | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response code |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response code |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| key_i | input | PIN_W | Push key pins, asynchronous |
| led_o | output | PIN_W | LED pins |

## Verification
The hardest condition to reach from the ports is a write whose address has been accepted while its data has not yet arrived, or the reverse. A master that drives both channels together never leaves the peripheral holding half a transaction. The bench's write task therefore has a mode that presents one channel alone and then idles for two cycles, checking that `led_o` has not moved, before it offers the other channel. The bench also holds back `s_bready` and `s_rready` for several cycles so that the response-hold rules are actually exercised. To catch the synchronizer latency, the bench issues a read so that its address is accepted exactly on the second edge after a key change.

// File: rtl/pinctl_pkg.sv
package pinctl_pkg;

  localparam int WORD_W = 32;
  localparam int LANES  = WORD_W / 8;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [LANES-1:0]  strb_t;

  // register select, taken from address bits [3:2]
  typedef enum logic [1:0] {
    SEL_IDENT = 2'd0,
    SEL_KEYS  = 2'd1,
    SEL_LAMPS = 2'd2,
    SEL_SCRAT = 2'd3
  } reg_sel_e;

  localparam logic [1:0] RESP_OKAY = 2'b00;

  // byte-lane merge: lanes with strobe set take the new byte
  function automatic word_t lane_merge(input word_t cur, input word_t nxt, input strb_t strb);
    word_t res;
    for (int i = 0; i < LANES; i++) begin
      res[i*8 +: 8] = strb[i] ? nxt[i*8 +: 8] : cur[i*8 +: 8];
    end
    return res;
  endfunction

  // read multiplexer over the four words
  function automatic word_t pick_word(input reg_sel_e sel, input word_t ident,
                                      input word_t keys, input word_t lamps,
                                      input word_t scrat);
    word_t res;
    case (sel)
      SEL_IDENT: res = ident;
      SEL_KEYS:  res = keys;
      SEL_LAMPS: res = lamps;
      default:   res = scrat;
    endcase
    return res;
  endfunction

endpackage

// File: rtl/pinctl_sync.sv
module pinctl_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/pinctl_wr_chan.sv
module pinctl_wr_chan
  import pinctl_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] awaddr,
  input  logic              awvalid,
  output logic              awready,
  input  word_t             wdata,
  input  strb_t             wstrb,
  input  logic              wvalid,
  output logic              wready,
  output logic [1:0]        bresp,
  output logic              bvalid,
  input  logic              bready,
  output logic              commit,
  output reg_sel_e          commit_sel,
  output word_t             commit_data,
  output strb_t             commit_strb
);

  logic              addr_held, data_held, resp_q;
  logic [ADDR_W-1:0] addr_q;
  word_t             data_q;
  strb_t             strb_q;
  logic              aw_take, w_take, b_take;

  assign awready = !addr_held && !resp_q;
  assign wready  = !data_held && !resp_q;
  assign aw_take = awvalid && awready;
  assign w_take  = wvalid && wready;
  assign b_take  = resp_q && bready;

  // a write lands only once both halves are held
  assign commit      = addr_held && data_held;
  assign commit_sel  = reg_sel_e'(addr_q[3:2]);
  assign commit_data = data_q;
  assign commit_strb = strb_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_held <= 1'b0;
      data_held <= 1'b0;
      resp_q    <= 1'b0;
      addr_q    <= '0;
      data_q    <= '0;
      strb_q    <= '0;
    end else begin
      if (aw_take) begin
        addr_held <= 1'b1;
        addr_q    <= awaddr;
      end
      if (w_take) begin
        data_held <= 1'b1;
        data_q    <= wdata;
        strb_q    <= wstrb;
      end
      if (commit) begin
        addr_held <= 1'b0;
        data_held <= 1'b0;
        resp_q    <= 1'b1;
      end else if (b_take) begin
        resp_q <= 1'b0;
      end
    end
  end

  assign bvalid = resp_q;
  assign bresp  = RESP_OKAY;

  logic unused_addr_bits;
  assign unused_addr_bits = ^{addr_q[1:0]};

  // R9
  bresp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bvalid && !bready |=> bvalid);

  // R9
  commit_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> bvalid && !commit);

  // R8
  half_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    aw_take && !data_held && !w_take |=> !commit);

endmodule

// File: rtl/pinctl_rd_chan.sv
module pinctl_rd_chan
  import pinctl_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] araddr,
  input  logic              arvalid,
  output logic              arready,
  output word_t             rdata,
  output logic [1:0]        rresp,
  output logic              rvalid,
  input  logic              rready,
  output reg_sel_e          look_sel,
  input  word_t             look_word
);

  logic  valid_q;
  word_t data_q;
  logic  ar_take;

  assign arready  = !valid_q;
  assign ar_take  = arvalid && arready;
  assign look_sel = reg_sel_e'(araddr[3:2]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (ar_take) begin
      valid_q <= 1'b1;
      data_q  <= look_word;
    end else if (valid_q && rready) begin
      valid_q <= 1'b0;
    end
  end

  assign rvalid = valid_q;
  assign rdata  = data_q;
  assign rresp  = RESP_OKAY;

  logic unused_araddr_bits;
  assign unused_araddr_bits = ^{araddr[1:0]};

  // R10
  rvalid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid && !rready |=> rvalid && $stable(rdata));

  // R10
  read_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ar_take |=> rvalid);

endmodule

// File: rtl/pinctl_axil.sv
module pinctl_axil
  import pinctl_pkg::*;
#(
  parameter int          ADDR_W  = 4,
  parameter int          PIN_W   = 4,
  parameter logic [31:0] VERSION = 32'hC0DE_0102
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] s_awaddr,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [31:0]       s_wdata,
  input  logic [3:0]        s_wstrb,
  input  logic              s_wvalid,
  output logic              s_wready,
  output logic [1:0]        s_bresp,
  output logic              s_bvalid,
  input  logic              s_bready,
  input  logic [ADDR_W-1:0] s_araddr,
  input  logic              s_arvalid,
  output logic              s_arready,
  output logic [31:0]       s_rdata,
  output logic [1:0]        s_rresp,
  output logic              s_rvalid,
  input  logic              s_rready,
  input  logic [PIN_W-1:0]  key_i,
  output logic [PIN_W-1:0]  led_o
);

  localparam int SYNC_STAGES = 2;

  logic             commit;
  reg_sel_e         commit_sel;
  word_t            commit_data;
  strb_t            commit_strb;
  reg_sel_e         look_sel;
  word_t            look_word;
  logic [PIN_W-1:0] key_sync;
  logic [PIN_W-1:0] lamp_q;
  word_t            scrat_q;
  word_t            lamp_word, key_word, lamp_next;
  logic             lamp_wr, scrat_wr;

  pinctl_wr_chan #(.ADDR_W(ADDR_W)) u_wr (
    .clk         (clk),
    .rst_n       (rst_n),
    .awaddr      (s_awaddr),
    .awvalid     (s_awvalid),
    .awready     (s_awready),
    .wdata       (s_wdata),
    .wstrb       (s_wstrb),
    .wvalid      (s_wvalid),
    .wready      (s_wready),
    .bresp       (s_bresp),
    .bvalid      (s_bvalid),
    .bready      (s_bready),
    .commit      (commit),
    .commit_sel  (commit_sel),
    .commit_data (commit_data),
    .commit_strb (commit_strb)
  );

  pinctl_rd_chan #(.ADDR_W(ADDR_W)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .araddr    (s_araddr),
    .arvalid   (s_arvalid),
    .arready   (s_arready),
    .rdata     (s_rdata),
    .rresp     (s_rresp),
    .rvalid    (s_rvalid),
    .rready    (s_rready),
    .look_sel  (look_sel),
    .look_word (look_word)
  );

  pinctl_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (key_i),
    .sync_o  (key_sync)
  );

  // zero-extended views of the narrow registers
  assign key_word  = word_t'(key_sync);
  assign lamp_word = word_t'(lamp_q);
  assign lamp_next = lane_merge(lamp_word, commit_data, commit_strb);

  assign lamp_wr  = commit && (commit_sel == SEL_LAMPS);
  assign scrat_wr = commit && (commit_sel == SEL_SCRAT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lamp_q  <= '0;
      scrat_q <= '0;
    end else begin
      if (lamp_wr)  lamp_q  <= lamp_next[PIN_W-1:0];
      if (scrat_wr) scrat_q <= lane_merge(scrat_q, commit_data, commit_strb);
    end
  end

  assign look_word = pick_word(look_sel, VERSION, key_word, lamp_word, scrat_q);
  assign led_o     = lamp_q;

  logic unused_lamp_hi;
  assign unused_lamp_hi = ^{lamp_next[31:PIN_W]};

  // R4
  lamp_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit && commit_sel == SEL_LAMPS && commit_strb[0]
      |=> led_o == $past(commit_data[PIN_W-1:0]));

  // R7
  ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit && (commit_sel == SEL_IDENT || commit_sel == SEL_KEYS)
      |=> $stable(led_o) && $stable(scrat_q));

  // R5
  scratch_isolated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit && commit_sel == SEL_SCRAT |=> $stable(led_o));

  // R1
  reset_dark_chk: assert property (@(posedge clk)
    !rst_n |=> led_o == '0 && !s_bvalid && !s_rvalid);

endmodule

// File: tb/pinctl_axil_bench.sv
module pinctl_axil_bench;

  localparam logic [31:0] BENCH_VER = 32'h5A17_0042;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  awaddr = '0, araddr = '0;
  logic        awvalid = 0, wvalid = 0, bready = 0, arvalid = 0, rready = 0;
  logic [31:0] wdata = '0;
  logic [3:0]  wstrb = '0;
  logic        awready, wready, bvalid, arready, rvalid;
  logic [1:0]  bresp, rresp;
  logic [31:0] rdata;
  logic [3:0]  key_i = '0;
  logic [3:0]  led_o;

  int checks = 0;
  int errors = 0;
  logic [3:0]  led_m = '0;
  logic [31:0] scr_m = '0;

  always #4 clk = ~clk;  // 125 MHz

  pinctl_axil #(.ADDR_W(4), .PIN_W(4), .VERSION(BENCH_VER)) u_pinctl_axil (
    .clk(clk), .rst_n(rst_n),
    .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awready),
    .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid), .s_wready(wready),
    .s_bresp(bresp), .s_bvalid(bvalid), .s_bready(bready),
    .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arready),
    .s_rdata(rdata), .s_rresp(rresp), .s_rvalid(rvalid), .s_rready(rready),
    .key_i(key_i), .led_o(led_o)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] n, input logic [3:0] s);
    logic [31:0] r = o;
    if (s[0]) r[7:0]   = n[7:0];
    if (s[1]) r[15:8]  = n[15:8];
    if (s[2]) r[23:16] = n[23:16];
    if (s[3]) r[31:24] = n[31:24];
    return r;
  endfunction

  // mode 0: address first, 1: data first, 2: together
  task automatic axi_write(input logic [3:0] a, input logic [31:0] d, input logic [3:0] s,
                           input int mode, input int bwait);
    bit aw_done = 0, w_done = 0, ok_aw, ok_w;
    @(negedge clk);
    if (mode != 1) begin awaddr = a; awvalid = 1; end
    if (mode != 0) begin wdata = d; wstrb = s; wvalid = 1; end
    while (!(aw_done && w_done)) begin
      ok_aw = awvalid && awready;
      ok_w  = wvalid && wready;
      @(negedge clk);
      if (ok_aw) begin awvalid = 0; aw_done = 1; end
      if (ok_w)  begin wvalid = 0; w_done = 1; end
      if (aw_done && !w_done && !wvalid) begin
        repeat (2) @(negedge clk);
        check(led_o == led_m && !bvalid, "R8 address alone", {28'd0, led_o}, {28'd0, led_m});
        wdata = d; wstrb = s; wvalid = 1;
      end
      if (w_done && !aw_done && !awvalid) begin
        repeat (2) @(negedge clk);
        check(led_o == led_m && !bvalid, "R8 data alone", {28'd0, led_o}, {28'd0, led_m});
        awaddr = a; awvalid = 1;
      end
    end
    while (!bvalid) @(negedge clk);
    for (int i = 0; i < bwait; i++) begin
      @(negedge clk);
      check(bvalid, "R9 bvalid held", {31'd0, bvalid}, 32'd1);
    end
    check(bresp == 2'b00, "R9 bresp OKAY", {30'd0, bresp}, 32'd0);
    bready = 1;
    @(negedge clk);
    bready = 0;
    check(!bvalid, "R9 single response", {31'd0, bvalid}, 32'd0);
  endtask

  task automatic axi_read(input logic [3:0] a, input int rwait, output logic [31:0] d);
    bit ok;
    @(negedge clk);
    araddr = a; arvalid = 1;
    do begin ok = arready; @(negedge clk); end while (!ok);
    arvalid = 0;
    while (!rvalid) @(negedge clk);
    d = rdata;
    for (int i = 0; i < rwait; i++) begin
      @(negedge clk);
      check(rvalid && rdata == d, "R10 rdata held", rdata, d);
    end
    check(rresp == 2'b00, "R10 rresp OKAY", {30'd0, rresp}, 32'd0);
    rready = 1;
    @(negedge clk);
    rready = 0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check(led_o == 4'h0 && !bvalid && !rvalid, "R1 in reset", {28'd0, led_o}, 32'd0);
    @(negedge clk); rst_n = 1;
    check(led_o == 4'h0, "R1 after release", {28'd0, led_o}, 32'd0);
    axi_read(4'h8, 0, v); check(v == 0, "R1 led reg zero", v, 0);
    axi_read(4'hC, 0, v); check(v == 0, "R1 scratch zero", v, 0);
  endtask

  task automatic t_version();
    logic [31:0] v;
    axi_read(4'h0, 3, v); check(v == BENCH_VER, "R2 version word", v, BENCH_VER);
  endtask

  task automatic t_keys();
    logic [31:0] v;
    @(negedge clk); key_i = 4'b0101;
    repeat (3) @(negedge clk);
    axi_read(4'h4, 0, v); check(v == 32'h5, "R3 keys 0101", v, 32'h5);
    key_i = 4'b1010;  // read below is accepted on the second edge
    axi_read(4'h4, 0, v); check(v == 32'h5, "R3 sync latency", v, 32'h5);
    axi_read(4'h4, 0, v); check(v == 32'hA, "R3 keys 1010", v, 32'hA);
  endtask

  task automatic t_led_orders();
    logic [31:0] v;
    axi_write(4'h8, 32'hFFFF_FFF9, 4'hF, 0, 2); led_m = 4'h9;
    check(led_o == led_m, "R4 led addr-first", {28'd0, led_o}, {28'd0, led_m});
    axi_read(4'h8, 0, v); check(v == 32'h9, "R4 readback upper zero", v, 32'h9);
    axi_write(4'h8, 32'h6, 4'hF, 1, 0); led_m = 4'h6;
    check(led_o == led_m, "R4 led data-first", {28'd0, led_o}, {28'd0, led_m});
    axi_write(4'h8, 32'hF, 4'hF, 2, 4); led_m = 4'hF;
    check(led_o == led_m, "R4 led together", {28'd0, led_o}, {28'd0, led_m});
  endtask

  task automatic t_scratch_strobes();
    logic [31:0] v;
    axi_write(4'hC, 32'hAABB_CCDD, 4'hF, 2, 0); scr_m = 32'hAABB_CCDD;
    axi_read(4'hC, 0, v); check(v == scr_m, "R5 scratch readback", v, scr_m);
    check(led_o == led_m, "R5 led untouched", {28'd0, led_o}, {28'd0, led_m});
    axi_write(4'hC, 32'h1122_3344, 4'b0101, 0, 1); scr_m = merge(scr_m, 32'h1122_3344, 4'b0101);
    axi_read(4'hC, 0, v); check(v == scr_m, "R6 partial lanes", v, scr_m);
    axi_write(4'h8, 32'h0, 4'b1110, 2, 0);
    check(led_o == led_m, "R6 lane0 off keeps led", {28'd0, led_o}, {28'd0, led_m});
  endtask

  task automatic t_ignored();
    logic [31:0] v;
    axi_write(4'h0, 32'h0, 4'hF, 2, 0);
    axi_read(4'h0, 0, v); check(v == BENCH_VER, "R7 version kept", v, BENCH_VER);
    axi_write(4'h4, 32'h0, 4'hF, 1, 0);
    check(led_o == led_m, "R7 led kept", {28'd0, led_o}, {28'd0, led_m});
    axi_read(4'h4, 0, v); check(v == 32'hA, "R7 keys kept", v, 32'hA);
    axi_read(4'hC, 0, v); check(v == scr_m, "R7 scratch kept", v, scr_m);
  endtask

  task automatic t_alias();
    logic [31:0] v;
    axi_write(4'hB, 32'h3, 4'hF, 2, 0); led_m = 4'h3;
    check(led_o == led_m, "R11 write at 0xB", {28'd0, led_o}, {28'd0, led_m});
    axi_read(4'hE, 0, v); check(v == scr_m, "R11 read at 0xE", v, scr_m);
    axi_read(4'h1, 0, v); check(v == BENCH_VER, "R11 read at 0x1", v, BENCH_VER);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    t_version();
    t_keys();
    t_led_orders();
    t_scratch_strobes();
    t_ignored();
    t_alias();
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule